// File: doc/BRIEF.md
# USB IN Endpoint Event Controller

This block holds the transmit-side decision and event logic for a handful of IN endpoints of a USB device. An abstract serial engine reports three kinds of packet-level events: an IN token addressed to an endpoint, an acknowledged transmission, and the start of a frame. One cycle after each token, the block tells the engine how to answer it. The answer is a data packet, a NAK, or a zero-length packet. The choice depends on each endpoint's transfer type and on its buffer state.

Endpoint 0 is the control endpoint, and software always loads it by hand. The other endpoints are bulk, interrupt or isochronous, as chosen by parameter masks. Bulk and interrupt endpoints raise sticky per-endpoint interrupt flags. Isochronous endpoints raise none of their own, so software paces them with the frame flag. Software reaches the block through a 32-bit word-addressed register port: interrupt status with write-one-to-clear, a NAK-interrupt enable per endpoint type, and write-one-to-set buffer flags.

Top module: `usb_in_evt`

## Requirements
- R1: After reset all interrupt flags, buffer flags and NAK enables read as zero, and `resp_valid` is low.
- R2: A token to a non-isochronous endpoint is answered exactly one cycle later on `resp_valid`/`resp_kind`. The answer is DATA (code 1) if the endpoint's buffer is full, and NAK (code 2) if it is not. A cycle without a token produces no response.
- R3: An acknowledge (`ack_valid`) for a non-isochronous endpoint sets that endpoint's flag (status bit n = endpoint n) and clears its buffer-full flag.
- R4: A NAK answer sets the endpoint's flag only when the enable bit for its type is set in the NAK enable register at offset 0x04. Bit 0 covers control, bit 1 covers bulk and bit 2 covers interrupt.
- R5: A token to an isochronous endpoint is answered DATA (code 1) when its buffer is validated, and zero-length (code 3) otherwise. Sending DATA clears the validated flag.
- R6: An isochronous endpoint never sets its own flag, whether it receives an acknowledge or a token.
- R7: An isochronous endpoint sends at most one DATA packet per frame. A token that arrives after a DATA packet in the same frame is answered zero-length even if the buffer has been validated again. A frame start lifts this limit.
- R8: A `sof` pulse sets the frame flag, which is status bit 31.
- R9: Writing ones to the status register at offset 0x00 clears those flags. A flag that is set by an event in the same cycle as its clear stays set.
- R10: Reads of any offset other than 0x00, 0x04 and 0x08 return 0xDEADABBA.
- R11: Writing ones to offset 0x08 sets the matching buffer flags (full or validated), and reading 0x08 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | IN token received this cycle |
| tok_ep | input | EPW | Endpoint addressed by the token |
| ack_valid | input | 1 | Host acknowledged a sent packet |
| ack_ep | input | EPW | Endpoint of the acknowledged packet |
| sof | input | 1 | Frame start pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| resp_valid | output | 1 | Response to the previous cycle's token |
| resp_kind | output | 2 | 1 DATA, 2 NAK, 3 zero-length |

## Verification
A software clear of a status bit can land in the same cycle as the hardware event that sets that bit. This collision is provoked twice. In the first case, the bench drives an acknowledge on a bulk endpoint while writing a one to that endpoint's status bit. In the second, it pulses `sof` while writing a one to bit 31. In both cases the bench reads status afterwards and expects the bit to be set. A second overlap concerns isochronous endpoints: software revalidates a buffer within a frame in which a packet has already been sent. The next token must still get a zero-length answer, and a data answer must follow only after the next frame start.

// File: rtl/usb_in_evt.sv
module usb_in_evt #(
  parameter int NUM_EP = 4,
  parameter logic [NUM_EP-1:0] ISO_MASK  = 4'b1000,
  parameter logic [NUM_EP-1:0] INTR_MASK = 4'b0100,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tok_valid,
  input  logic [EPW-1:0] tok_ep,
  input  logic           ack_valid,
  input  logic [EPW-1:0] ack_ep,
  input  logic           sof,
  input  logic           reg_we,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           resp_valid,
  output logic [1:0]     resp_kind
);
  localparam logic [NUM_EP-1:0] ISO = ISO_MASK & ~NUM_EP'(1);
  localparam logic [1:0] K_DATA = 2'd1, K_NAK = 2'd2, K_ZLP = 2'd3;

  logic [NUM_EP-1:0] ep_flag, bufv, sent, nak_ok;
  logic              frm_flag;
  logic [2:0]        nak_en;

  logic [NUM_EP-1:0] tok_oh, ack_oh, clr, bset, iso_send, nak_hit, ep_set;
  logic              wr_stat, wr_nak, wr_buf;

  assign tok_oh  = tok_valid ? (NUM_EP'(1) << tok_ep) : '0;
  assign ack_oh  = ack_valid ? (NUM_EP'(1) << ack_ep) : '0;
  assign wr_stat = reg_we && reg_addr[7:2] == 6'd0;
  assign wr_nak  = reg_we && reg_addr[7:2] == 6'd1;
  assign wr_buf  = reg_we && reg_addr[7:2] == 6'd2;
  assign clr     = wr_stat ? reg_wdata[NUM_EP-1:0] : '0;
  assign bset    = wr_buf  ? reg_wdata[NUM_EP-1:0] : '0;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_type
    if (i == 0)             assign nak_ok[i] = nak_en[0];
    else if (INTR_MASK[i])  assign nak_ok[i] = nak_en[2];
    else                    assign nak_ok[i] = nak_en[1];
  end

  assign iso_send = tok_oh & ISO & bufv & ~sent;
  assign nak_hit  = tok_oh & ~ISO & ~bufv;
  assign ep_set   = (ack_oh & ~ISO) | (nak_hit & nak_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_flag    <= '0;
      bufv       <= '0;
      sent       <= '0;
      frm_flag   <= 1'b0;
      nak_en     <= '0;
      resp_valid <= 1'b0;
      resp_kind  <= '0;
    end else begin
      ep_flag  <= (ep_flag & ~clr) | ep_set;
      bufv     <= (bufv & ~((ack_oh & ~ISO) | iso_send)) | bset;
      sent     <= sof ? '0 : (sent | iso_send);
      frm_flag <= (frm_flag & ~(wr_stat & reg_wdata[31])) | sof;
      if (wr_nak) nak_en <= reg_wdata[2:0];
      resp_valid <= tok_valid;
      if (tok_valid) begin
        if (ISO[tok_ep]) resp_kind <= (|iso_send) ? K_DATA : K_ZLP;
        else             resp_kind <= (|(tok_oh & bufv)) ? K_DATA : K_NAK;
      end
    end
  end

  always_comb begin
    case (reg_addr[7:2])
      6'd0:    reg_rdata = {frm_flag, 31'(ep_flag)};
      6'd1:    reg_rdata = {29'd0, nak_en};
      6'd2:    reg_rdata = 32'(bufv);
      default: reg_rdata = 32'hDEADABBA;
    endcase
  end
endmodule

module usb_in_evt_chk #(
  parameter int NUM_EP = 4,
  parameter logic [NUM_EP-1:0] ISO_MASK = 4'b1000,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [EPW-1:0]    tok_ep,
  input logic              ack_valid,
  input logic [EPW-1:0]    ack_ep,
  input logic              sof,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic              resp_valid,
  input logic [1:0]        resp_kind,
  input logic [NUM_EP-1:0] ep_flag,
  input logic              frm_flag
);
  localparam logic [NUM_EP-1:0] ISO = ISO_MASK & ~NUM_EP'(1);

  a_r2_resp_after_tok: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> resp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !resp_valid);
  a_r3_ack_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ISO[ack_ep]) |=> ep_flag[$past(ack_ep)]);
  a_r5_iso_never_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ISO[tok_ep]) |=> resp_kind != 2'd2);
  a_r6_iso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (ep_flag & ISO) == '0);
  a_r8_sof_sets_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> frm_flag);
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr[7:2] == 6'd0) |=>
      ((ep_flag & $past(ep_flag)) == $past(ep_flag)));
endmodule

bind usb_in_evt usb_in_evt_chk #(.NUM_EP(NUM_EP), .ISO_MASK(ISO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
  .ack_valid(ack_valid), .ack_ep(ack_ep), .sof(sof), .reg_we(reg_we),
  .reg_addr(reg_addr), .resp_valid(resp_valid), .resp_kind(resp_kind),
  .ep_flag(ep_flag), .frm_flag(frm_flag)
);

// File: tb/tb_usb_in_evt.sv
`timescale 1ns/1ps
module tb_usb_in_evt;
  localparam logic [1:0] K_DATA = 2'd1, K_NAK = 2'd2, K_ZLP = 2'd3;

  logic        clk = 0, rst_n = 0;
  logic        tok_valid = 0, ack_valid = 0, sof = 0, reg_we = 0;
  logic [1:0]  tok_ep = 0, ack_ep = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        resp_valid;
  logic [1:0]  resp_kind;

  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_kind[$];
  string      exp_req[$];

  usb_in_evt dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic tok(logic [1:0] ep, logic [1:0] k, string req);
    @(negedge clk); tok_valid = 1; tok_ep = ep;
    exp_kind.push_back(k); exp_req.push_back(req);
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic ack(logic [1:0] ep);
    @(negedge clk); ack_valid = 1; ack_ep = ep;
    @(negedge clk); ack_valid = 0;
  endtask

  // monitor: pops one expected answer per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_kind.size() == 0) check("R2 unexpected response", 32'(resp_kind), 32'd0);
      else check(exp_req.pop_front(), 32'(resp_kind), 32'(exp_kind.pop_front()));
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 resp_valid", 32'(resp_valid), 0);
    rd("R1 status", 8'h00, 0);
    rd("R1 nak enable", 8'h04, 0);
    rd("R1 buffers", 8'h08, 0);
    rd("R10 unused 0x10", 8'h10, 32'hDEADABBA);
    rd("R10 unused 0xFC", 8'hFC, 32'hDEADABBA);

    tok(1, K_NAK, "R2 bulk empty nak");
    rd("R4 nak disabled no flag", 8'h00, 0);
    wr(8'h04, 32'h2);
    tok(1, K_NAK, "R2 bulk empty nak");
    rd("R4 bulk nak flag", 8'h00, 32'h2);
    tok(2, K_NAK, "R2 intr empty nak");
    rd("R4 intr type disabled", 8'h00, 32'h2);
    wr(8'h00, 32'h2);
    rd("R9 write one clears", 8'h00, 0);

    wr(8'h08, 32'h2);
    rd("R11 buffer full readback", 8'h08, 32'h2);
    tok(1, K_DATA, "R2 bulk full data");
    rd("R2 data sets no flag", 8'h00, 0);
    ack(1);
    rd("R3 ack sets flag", 8'h00, 32'h2);
    rd("R3 ack clears full", 8'h08, 0);
    wr(8'h00, 32'hFFFF_FFFF);

    tok(3, K_ZLP, "R5 iso not validated zlp");
    wr(8'h08, 32'h8);
    rd("R11 iso validated readback", 8'h08, 32'h8);
    tok(3, K_DATA, "R5 iso validated data");
    rd("R5 send clears validated", 8'h08, 0);
    wr(8'h08, 32'h8);
    tok(3, K_ZLP, "R7 second packet same frame");
    rd("R7 buffer kept validated", 8'h08, 32'h8);
    ack(3);
    rd("R6 iso ack no flag", 8'h00, 0);
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    rd("R8 frame flag", 8'h00, 32'h8000_0000);
    tok(3, K_DATA, "R7 new frame data");
    rd("R5 send clears validated", 8'h08, 0);

    wr(8'h00, 32'hFFFF_FFFF);
    rd("R9 clear all", 8'h00, 0);
    @(negedge clk); ack_valid = 1; ack_ep = 1; reg_we = 1; reg_addr = 8'h00; reg_wdata = 32'h2;
    @(negedge clk); ack_valid = 0; reg_we = 0;
    rd("R9 set wins over clear ep", 8'h00, 32'h2);
    @(negedge clk); sof = 1; reg_we = 1; reg_addr = 8'h00; reg_wdata = 32'h8000_0000;
    @(negedge clk); sof = 0; reg_we = 0;
    rd("R9 set wins over clear frame", 8'h00, 32'h8000_0002);

    wr(8'h04, 32'h4);
    wr(8'h00, 32'hFFFF_FFFF);
    tok(2, K_NAK, "R2 intr empty nak");
    rd("R4 intr nak flag", 8'h00, 32'h4);
    tok(1, K_NAK, "R2 bulk empty nak");
    rd("R4 bulk disabled now", 8'h00, 32'h4);

    repeat (3) @(negedge clk);
    check("R2 all responses seen", 32'(exp_kind.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule